// File: doc/BRIEF.md
# Speculative One-Tap-and-Beyond DFE Slicer

This block makes binary data decisions on a stream of signed, already-digitised receiver samples while removing trailing intersymbol interference in the manner of a decision-feedback equalizer. It does not subtract weighted past decisions from the sample before slicing. Instead it compares each sample at once against every threshold that the past decisions could call for. The actual past decisions then pick one of those results. The loop that closes from one decision to the next holds only a selector and a register, with no adder in it.

With the default single tap, the sample is compared against `+w1` and `-w1`. When the prior decision was +1, the `+w1` result is kept; when it was -1, the `-w1` result is kept. A build parameter widens the scheme to two or three taps. The comparator count then becomes 2^N, one for each combination of the N most recent decision signs. The registered decision and every speculative comparison leave the block in the same cycle, so they can be checked bit for bit against a plain subtract-then-slice equalizer.

Top module: `dfe_unrolled_slicer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_vld` is 0, `out_dec` is 0 and every bit of `out_spec` is 0. The decision history is all -1.
- R2: For each accepted sample y, `out_spec[c]` is 1 exactly when y >= T_c. T_c is the sum over taps j = 1..N of +w_j where bit j-1 of c is 1, and of -w_j where that bit is 0.
- R3: A sample exactly equal to a threshold gives a 1 (+1 decision) for that comparison.
- R4: `out_dec` equals `out_spec[h]`. Bit j-1 of h is the decision made j accepted samples earlier, with 1 meaning +1 and 0 meaning -1.
- R5: With one tap, if the prior decision was +1 the decision is 1 exactly when y >= w1; if it was -1, the decision is 1 exactly when y >= -w1.
- R6: A sample accepted on a clock edge (`in_vld` high) shows on `out_dec` and `out_spec` after that edge, and `out_vld` is high for exactly that one cycle.
- R7: While `in_vld` is low, the sample and tap inputs are ignored. `out_dec`, `out_spec` and the decision history keep their values, and `out_vld` is 0.
- R8: The decision sequence matches bit for bit that of a direct-feedback equalizer, z = y - sum of w_j * d(k-j) with d = +1/-1, deciding 1 exactly when z >= 0.
- R9: Tap values are sampled together with each accepted sample, so a change applies from the next accepted sample on.
- R10: Thresholds use widened arithmetic, so extreme samples (-128, 127) and taps (-128..127) never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Sample strobe; the sample and taps are taken when high |
| in_sample | input | DATA_W | Signed two's-complement receiver sample |
| tap_w | input | NTAPS*W_W | Signed tap weights; tap j sits in bits [j*W_W-1 : (j-1)*W_W] |
| out_vld | output | 1 | High for one cycle after each accepted sample |
| out_dec | output | 1 | Final decision, 1 = +1, 0 = -1 |
| out_spec | output | 2^NTAPS | Registered speculative comparisons, indexed by history code |

## Verification
The assertions assume that `in_vld`, `in_sample` and `tap_w` hold known values at every rising edge outside reset, and that the taps are read only in cycles where `in_vld` is high. The tie and threshold-ordering properties rely on the sample and threshold being compared as signed values of one common width. The stimulus drives every input on the falling edge, so each input is settled a half period before it is sampled. It changes the sample and taps freely during idle cycles, both to show that they are ignored and to keep them fully defined. It places samples right on each threshold and at the full-scale limits.

// File: rtl/dfe_slicer_pkg.sv
package dfe_slicer_pkg;

  localparam int unsigned MAX_TAPS = 3;

  typedef enum logic {
    DEC_NEG = 1'b0,
    DEC_POS = 1'b1
  } dec_e;

  function automatic int unsigned combo_count(input int unsigned taps);
    return 32'd1 << taps;
  endfunction

  function automatic int unsigned cmp_width(input int unsigned dw, input int unsigned ww);
    return ((dw > ww) ? dw : ww) + 3;
  endfunction

endpackage

// File: rtl/dfe_thr_gen.sv
module dfe_thr_gen #(
  parameter int unsigned NTAPS = 1,
  parameter int unsigned W_W   = 8,
  parameter int unsigned THR_W = 11,
  parameter int unsigned NCOMB = 2
) (
  input  logic [NTAPS*W_W-1:0]   tap_w,
  output logic [NCOMB*THR_W-1:0] thr_flat
);

  function automatic logic signed [THR_W-1:0] code_threshold(
    input logic [NTAPS-1:0]     code,
    input logic [NTAPS*W_W-1:0] taps
  );
    logic signed [THR_W-1:0] acc;
    logic signed [THR_W-1:0] term;
    acc = '0;
    for (int j = 0; j < int'(NTAPS); j++) begin
      term = THR_W'(signed'(taps[j*W_W +: W_W]));
      acc  = code[j] ? (acc + term) : (acc - term);
    end
    return acc;
  endfunction

  for (genvar c = 0; c < int'(NCOMB); c++) begin : g_thr
    always_comb begin
      thr_flat[c*THR_W +: THR_W] = code_threshold(NTAPS'(c), tap_w);
    end
  end

endmodule

// File: rtl/dfe_cmp_bank.sv
module dfe_cmp_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned THR_W  = 11,
  parameter int unsigned NCOMB  = 2
) (
  input  logic [DATA_W-1:0]      in_sample,
  input  logic [NCOMB*THR_W-1:0] thr_flat,
  output logic [NCOMB-1:0]       spec_now
);

  function automatic logic at_or_above(
    input logic [DATA_W-1:0] smp,
    input logic [THR_W-1:0]  thr
  );
    logic signed [THR_W-1:0] s_ext;
    s_ext = THR_W'(signed'(smp));
    return s_ext >= signed'(thr);
  endfunction

  for (genvar c = 0; c < int'(NCOMB); c++) begin : g_cmp
    always_comb begin
      spec_now[c] = at_or_above(in_sample, thr_flat[c*THR_W +: THR_W]);
    end
  end

endmodule

// File: rtl/dfe_sel_reg.sv
module dfe_sel_reg #(
  parameter int unsigned NTAPS = 1,
  parameter int unsigned NCOMB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [NCOMB-1:0] spec_now,
  output logic             sel_bit,
  output logic [NTAPS-1:0] hist_q,
  output logic             out_vld,
  output logic             out_dec,
  output logic [NCOMB-1:0] out_spec
);

  import dfe_slicer_pkg::*;

  logic [NTAPS-1:0] hist_d;

  always_comb begin
    sel_bit = spec_now[hist_q];
  end

  if (NTAPS == 1) begin : g_hist1
    always_comb hist_d = sel_bit;
  end else begin : g_histn
    always_comb hist_d = {hist_q[NTAPS-2:0], sel_bit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_dec  <= DEC_NEG;
      out_spec <= '0;
      hist_q   <= {NTAPS{DEC_NEG}};
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_dec  <= sel_bit;
        out_spec <= spec_now;
        hist_q   <= hist_d;
      end
    end
  end

endmodule

// File: rtl/dfe_unrolled_slicer.sv
module dfe_unrolled_slicer
  import dfe_slicer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned W_W    = 8,
  parameter int unsigned NTAPS  = 1,
  localparam int unsigned NCOMB = combo_count(NTAPS),
  localparam int unsigned THR_W = cmp_width(DATA_W, W_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [DATA_W-1:0]    in_sample,
  input  logic [NTAPS*W_W-1:0] tap_w,
  output logic                 out_vld,
  output logic                 out_dec,
  output logic [NCOMB-1:0]     out_spec
);

  logic [NCOMB*THR_W-1:0] thr_flat;
  logic [NCOMB-1:0]       spec_now;
  logic [NTAPS-1:0]       hist_q;
  logic                   sel_bit;

  dfe_thr_gen #(
    .NTAPS(NTAPS), .W_W(W_W), .THR_W(THR_W), .NCOMB(NCOMB)
  ) u_thr (
    .tap_w    (tap_w),
    .thr_flat (thr_flat)
  );

  dfe_cmp_bank #(
    .DATA_W(DATA_W), .THR_W(THR_W), .NCOMB(NCOMB)
  ) u_cmp (
    .in_sample (in_sample),
    .thr_flat  (thr_flat),
    .spec_now  (spec_now)
  );

  dfe_sel_reg #(
    .NTAPS(NTAPS), .NCOMB(NCOMB)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .spec_now (spec_now),
    .sel_bit  (sel_bit),
    .hist_q   (hist_q),
    .out_vld  (out_vld),
    .out_dec  (out_dec),
    .out_spec (out_spec)
  );

endmodule

// File: rtl/dfe_slicer_checker.sv
module dfe_slicer_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NTAPS  = 1,
  parameter int unsigned NCOMB  = 2,
  parameter int unsigned THR_W  = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_vld,
  input logic [DATA_W-1:0]      in_sample,
  input logic [NCOMB*THR_W-1:0] thr_flat,
  input logic [NTAPS-1:0]       hist_q,
  input logic                   out_vld,
  input logic                   out_dec,
  input logic [NCOMB-1:0]       out_spec
);

  logic signed [THR_W-1:0] smp_ext;
  always_comb smp_ext = THR_W'(signed'(in_sample));

  // R4: the final decision is the speculative result picked by the prior history
  a_r4_select: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (out_dec == out_spec[$past(hist_q)]));

  // R6: a one-cycle valid pulse follows every accepted sample
  a_r6_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R7: idle cycles leave the outputs and the history untouched
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_dec) && $stable(out_spec) && $stable(hist_q)));

  // R6: the newest history bit is the decision just shown
  a_r6_hist_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (hist_q[0] == out_dec));

  for (genvar c = 0; c < int'(NCOMB); c++) begin : g_tie
    // R3: a sample sitting on a threshold resolves to +1
    a_r3_tie: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (smp_ext == signed'(thr_flat[c*THR_W +: THR_W]))) |=> out_spec[c]);
  end

  for (genvar a = 0; a < int'(NCOMB); a++) begin : g_ord_a
    for (genvar b = 0; b < int'(NCOMB); b++) begin : g_ord_b
      // R2: clearing a higher threshold implies clearing every lower one
      a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (signed'(thr_flat[a*THR_W +: THR_W]) <= signed'(thr_flat[b*THR_W +: THR_W])))
        |=> (!out_spec[b] || out_spec[a]));
    end
  end

endmodule

bind dfe_unrolled_slicer dfe_slicer_checker #(
  .DATA_W(DATA_W), .NTAPS(NTAPS), .NCOMB(NCOMB), .THR_W(THR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .in_sample (in_sample),
  .thr_flat  (thr_flat),
  .hist_q    (hist_q),
  .out_vld   (out_vld),
  .out_dec   (out_dec),
  .out_spec  (out_spec)
);

// File: tb/sim_dfe_unrolled_slicer.sv
`timescale 1ns/1ps
module sim_dfe_unrolled_slicer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic signed [7:0] smp = '0;
  logic signed [7:0] ta [3];
  logic signed [7:0] tb [3];

  logic       vld0, dec0;
  logic [1:0] spec0;
  logic       vld1, dec1;
  logic [7:0] spec1;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  dfe_unrolled_slicer #(.DATA_W(8), .W_W(8), .NTAPS(1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sample(smp),
    .tap_w(ta[0]), .out_vld(vld0), .out_dec(dec0), .out_spec(spec0));

  dfe_unrolled_slicer #(.DATA_W(8), .W_W(8), .NTAPS(3)) u1 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sample(smp),
    .tap_w({tb[2], tb[1], tb[0]}), .out_vld(vld1), .out_dec(dec1), .out_spec(spec1));

  // reference model: direct subtraction DFE, decisions kept as +1/-1 integers
  int hist_a[$];
  int hist_b[$];
  bit exp_vld = 0;
  bit exp_dec0 = 0, exp_dec1 = 0;
  bit [1:0] exp_spec0 = '0;
  bit [7:0] exp_spec1 = '0;

  function automatic bit direct_dec(int y, int w0, int w1, int w2, int n, int h[$]);
    int z = y;
    int w[3] = '{w0, w1, w2};
    for (int j = 0; j < n; j++) z = z - w[j] * h[j];
    return (z >= 0);
  endfunction

  function automatic bit guess(int y, int w0, int w1, int w2, int n, int code);
    int t = 0;
    int w[3] = '{w0, w1, w2};
    for (int j = 0; j < n; j++) t = t + (((code >> j) & 1) != 0 ? w[j] : -w[j]);
    return (y >= t);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist_a = '{-1};
      hist_b = '{-1, -1, -1};
      exp_vld = 0; exp_dec0 = 0; exp_dec1 = 0; exp_spec0 = '0; exp_spec1 = '0;
    end else begin
      exp_vld = in_vld;
      if (in_vld) begin
        for (int c = 0; c < 2; c++) exp_spec0[c] = guess(smp, ta[0], 0, 0, 1, c);
        for (int c = 0; c < 8; c++) exp_spec1[c] = guess(smp, tb[0], tb[1], tb[2], 3, c);
        exp_dec0 = direct_dec(smp, ta[0], 0, 0, 1, hist_a);
        exp_dec1 = direct_dec(smp, tb[0], tb[1], tb[2], 3, hist_b);
        hist_a.push_front(exp_dec0 ? 1 : -1); void'(hist_a.pop_back());
        hist_b.push_front(exp_dec1 ? 1 : -1); void'(hist_b.pop_back());
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(vld0 == exp_vld && vld1 == exp_vld, {tag, " R6 valid"}, {vld1, vld0}, {exp_vld, exp_vld});
      check(dec0 == exp_dec0, {tag, " R4 R8 dec n1", exp_vld ? "" : " R7"}, dec0, exp_dec0);
      check(dec1 == exp_dec1, {tag, " R4 R8 dec n3", exp_vld ? "" : " R7"}, dec1, exp_dec1);
      check(spec0 == exp_spec0, {tag, " R2 spec n1"}, spec0, exp_spec0);
      check(spec1 == exp_spec1, {tag, " R2 spec n3"}, spec1, exp_spec1);
    end
  end

  task automatic push(int y);
    @(negedge clk);
    in_vld = 1'b1;
    smp = 8'(y);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      smp = 8'($urandom);
      ta[0] = 8'($urandom); tb[0] = 8'($urandom); tb[1] = 8'($urandom); tb[2] = 8'($urandom);
    end
  endtask

  task automatic set_taps(int a, int b0, int b1, int b2);
    ta[0] = 8'(a); tb[0] = 8'(b0); tb[1] = 8'(b1); tb[2] = 8'(b2);
  endtask

  initial begin
    set_taps(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(vld0 == 0 && dec0 == 0 && spec0 == 0, "R1 reset n1", {vld0, dec0}, 0);
    check(vld1 == 0 && dec1 == 0 && spec1 == 0, "R1 reset n3", {vld1, dec1}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vld0 == 0 && dec0 == 0 && spec0 == 0, "R1 after reset", {vld0, dec0}, 0);

    tag = "R5";
    set_taps(20, 10, 5, 2);
    push(30); push(10); push(-10); push(-25); push(19); push(-21); push(0);

    tag = "R3";
    set_taps(20, 10, 5, 2);
    push(-20); push(20); push(20); push(-20); push(-17); push(17); push(7); push(-3);

    tag = "R7";
    push(50); idle(3);
    set_taps(20, 10, 5, 2);
    push(-40); idle(2);
    set_taps(20, 10, 5, 2);
    push(5); idle(4);
    set_taps(20, 10, 5, 2);
    push(-5);

    tag = "R9";
    for (int i = 0; i < 12; i++) begin
      set_taps(i * 7 - 40, 30 - i * 5, i * 3 - 10, 12 - i);
      push(i * 9 - 50);
    end

    tag = "R10";
    set_taps(127, 127, 127, 127);   push(-128); push(127);
    set_taps(-128, -128, -128, -128); push(127); push(-128); push(-128);
    set_taps(127, -128, 127, -128); push(127); push(-128);

    tag = "R2";
    for (int i = 0; i < 600; i++) begin
      if (i % 40 == 0) set_taps($urandom_range(0, 90) - 30, $urandom_range(0, 80) - 20,
                                $urandom_range(0, 40) - 20, $urandom_range(0, 20) - 10);
      if ($urandom_range(0, 7) == 0) idle(1);
      if (i % 40 == 0) set_taps(ta[0] == 0 ? 15 : 25, 20, 8, -4);
      push($urandom_range(0, 255) - 128);
    end
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule